// File: doc/BRIEF.md
# Loop Playback Micro-op Buffer

This block sits between the instruction decoder and the scheduler. Decoded micro-ops normally flow straight through it to the scheduler. When the branch predictor flags the first micro-op of a tight backward loop, the block starts recording. It goes on recording each accepted micro-op until a micro-op arrives that carries the loop-close hint. During this first pass the micro-ops still reach the scheduler as normal.

Once a body has been recorded, the block stops accepting decoded micro-ops. It then feeds the stored sequence to the scheduler again and again, with no refetch. While it does this it raises a gate output, which lets the fetch and decode front end be powered down. Replay ends when the loop-closing branch resolves not taken, or when a redirect or flush arrives. Control then returns to normal fetch.

A body longer than the storage is never replayed. If the storage fills before the close hint arrives, the recording is dropped and the block stays in pass-through.

Top module: `loop_replay_buf`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, the block is in pass-through: `fe_gate` is 0 and `out_valid` equals `in_valid`.
- R2: In pass-through and while recording, `out_valid` = `in_valid`, `out_uop` = `in_uop` and `in_ready` = `out_ready`, all combinationally.
- R3: A micro-op is accepted when `in_valid` and `out_ready` are both 1 in pass-through. If an accepted micro-op has `in_loop_start` = 1, recording starts and that micro-op is stored as entry 0. A start hint seen while already recording is ignored.
- R4: A micro-op accepted while recording is stored at the next entry. If that micro-op, or the start micro-op itself, has `in_loop_end` = 1, playback begins in the following cycle. The loop body then holds every entry up to and including that micro-op. An end hint seen in pass-through is ignored.
- R5: In playback, `in_ready` = 0 and `out_valid` = 1. `out_uop` starts at entry 0 and steps one entry for each cycle with `out_ready` = 1. After the last body entry it wraps back to entry 0.
- R6: In playback, while `out_ready` = 0, `out_uop` holds its value.
- R7: If DEPTH micro-ops (48 by default) are accepted while recording and none carries the end hint, the recording is dropped and the block returns to pass-through. A body of exactly DEPTH micro-ops is still replayed.
- R8: `fe_gate` is 1 only in playback, and only in cycles where neither `flush` nor `loop_exit` is 1.
- R9: `loop_exit` = 1 in playback forces `out_valid` = 0 in that cycle. The block is in pass-through from the next cycle.
- R10: `flush` = 1 in any state forces `out_valid`, `in_ready` and `fe_gate` to 0 in that cycle. From the next cycle the block is in pass-through with the stored body discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decoded micro-op valid |
| in_ready | output | 1 | Block accepts the decoded micro-op |
| in_uop | input | UOP_W | Decoded micro-op |
| in_loop_start | input | 1 | Predictor hint: micro-op is first of a tight loop |
| in_loop_end | input | 1 | Predictor hint: micro-op is the loop-closing branch |
| out_valid | output | 1 | Micro-op to scheduler valid |
| out_ready | input | 1 | Scheduler can take a micro-op |
| out_uop | output | UOP_W | Micro-op to scheduler |
| loop_exit | input | 1 | Loop-closing branch resolved not taken |
| flush | input | 1 | Redirect or flush |
| fe_gate | output | 1 | Front end may be power-gated |

## Verification
The block has two kinds of result, and each is due at a different time.

Pass-through data, the effect of `flush` and `loop_exit` on the outputs, and `fe_gate` are combinational, so they are due in the same cycle as the stimulus. A state change happens one clock edge after it. That covers the start of playback, a step of the replay pointer, abandoning a recording, and the return to pass-through.

The bench drives inputs on the falling edge and compares all outputs shortly afterwards against a behavioural queue model, so same-cycle results are seen in the cycle they are due. The model then updates its state at the rising edge, so one-edge results are compared in the following cycle.

// File: rtl/lrb_pkg.sv
package lrb_pkg;

    localparam int unsigned LRB_UOP_W = 32;
    localparam int unsigned LRB_DEPTH = 48;

    typedef enum logic [1:0] {
        ST_PASS    = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_PLAY    = 2'd2
    } lrb_state_e;

    function automatic int unsigned ptr_next(int unsigned ptr, int unsigned last);
        return (ptr == last) ? 0 : ptr + 1;
    endfunction

endpackage

// File: rtl/lrb_store.sv
module lrb_store #(
    parameter int unsigned UOP_W = 32,
    parameter int unsigned DEPTH = 48,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_idx,
    input  logic [UOP_W-1:0] wr_data,
    input  logic [PTR_W-1:0] rd_idx,
    output logic [UOP_W-1:0] rd_data
);

    logic [UOP_W-1:0] mem_q [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == PTR_W'(e))) begin
                mem_q[e] <= wr_data;
            end
        end
    end

    assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/lrb_ctrl.sv
module lrb_ctrl
    import lrb_pkg::*;
#(
    parameter int unsigned DEPTH = 48,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_loop_start,
    input  logic             in_loop_end,
    input  logic             out_ready,
    input  logic             loop_exit,
    input  logic             flush,
    output lrb_state_e       state,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_idx,
    output logic [PTR_W-1:0] rd_idx
);

    lrb_state_e       state_q;
    logic [PTR_W-1:0] cnt_q;
    logic [PTR_W-1:0] last_q;
    logic [PTR_W-1:0] rd_q;
    logic             acc;

    assign acc    = in_valid && out_ready && !flush && (state_q != ST_PLAY);
    assign wr_en  = acc && ((state_q == ST_CAPTURE) || in_loop_start);
    assign wr_idx = (state_q == ST_CAPTURE) ? cnt_q : '0;
    assign rd_idx = rd_q;
    assign state  = state_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            state_q <= ST_PASS;
            cnt_q   <= '0;
            last_q  <= '0;
            rd_q    <= '0;
        end else begin
            unique case (state_q)
                ST_PASS: begin
                    if (acc && in_loop_start) begin
                        cnt_q <= PTR_W'(1);
                        rd_q  <= '0;
                        if (in_loop_end) begin
                            state_q <= ST_PLAY;
                            last_q  <= '0;
                        end else begin
                            state_q <= ST_CAPTURE;
                        end
                    end
                end
                ST_CAPTURE: begin
                    if (acc) begin
                        if (in_loop_end) begin
                            state_q <= ST_PLAY;
                            last_q  <= cnt_q;
                            rd_q    <= '0;
                        end else if (cnt_q == PTR_W'(DEPTH - 1)) begin
                            state_q <= ST_PASS;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + PTR_W'(1);
                        end
                    end
                end
                ST_PLAY: begin
                    if (loop_exit) begin
                        state_q <= ST_PASS;
                        cnt_q   <= '0;
                    end else if (out_ready) begin
                        rd_q <= PTR_W'(ptr_next(int'(rd_q), int'(last_q)));
                    end
                end
                default: state_q <= ST_PASS;
            endcase
        end
    end

endmodule

// File: rtl/loop_replay_buf.sv
module loop_replay_buf
    import lrb_pkg::*;
#(
    parameter int unsigned UOP_W = LRB_UOP_W,
    parameter int unsigned DEPTH = LRB_DEPTH,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [UOP_W-1:0] in_uop,
    input  logic             in_loop_start,
    input  logic             in_loop_end,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [UOP_W-1:0] out_uop,
    input  logic             loop_exit,
    input  logic             flush,
    output logic             fe_gate
);

    lrb_state_e       state;
    logic             wr_en;
    logic [PTR_W-1:0] wr_idx;
    logic [PTR_W-1:0] rd_idx;
    logic [UOP_W-1:0] rd_data;
    logic             playing;

    lrb_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk           (clk),
        .rst           (rst),
        .in_valid      (in_valid),
        .in_loop_start (in_loop_start),
        .in_loop_end   (in_loop_end),
        .out_ready     (out_ready),
        .loop_exit     (loop_exit),
        .flush         (flush),
        .state         (state),
        .wr_en         (wr_en),
        .wr_idx        (wr_idx),
        .rd_idx        (rd_idx)
    );

    lrb_store #(.UOP_W(UOP_W), .DEPTH(DEPTH)) store_i (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (in_uop),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    assign playing = (state == ST_PLAY);

    always_comb begin
        if (flush) begin
            out_valid = 1'b0;
            in_ready  = 1'b0;
            out_uop   = in_uop;
            fe_gate   = 1'b0;
        end else if (playing) begin
            out_valid = !loop_exit;
            in_ready  = 1'b0;
            out_uop   = rd_data;
            fe_gate   = !loop_exit;
        end else begin
            out_valid = in_valid;
            in_ready  = out_ready;
            out_uop   = in_uop;
            fe_gate   = 1'b0;
        end
    end

endmodule

// File: rtl/lrb_checker.sv
module lrb_checker #(
    parameter int unsigned UOP_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [UOP_W-1:0] out_uop,
    input logic             loop_exit,
    input logic             flush,
    input logic             fe_gate
);

    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (rst)
        flush |-> (!out_valid && !in_ready && !fe_gate)); // R10

    AST_FLUSH_UNGATE: assert property (@(posedge clk) disable iff (rst)
        flush |=> !fe_gate); // R10

    AST_EXIT_UNGATE: assert property (@(posedge clk) disable iff (rst)
        loop_exit |=> !fe_gate); // R9

    AST_GATE_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
        fe_gate |-> (!in_ready && out_valid)); // R8

    AST_PASS_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (!flush && !loop_exit && !fe_gate) |-> (out_valid == in_valid && in_ready == out_ready)); // R2

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (fe_gate && !out_ready) |=> (!fe_gate || $stable(out_uop))); // R6

endmodule

bind loop_replay_buf lrb_checker #(.UOP_W(UOP_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_uop   (out_uop),
    .loop_exit (loop_exit),
    .flush     (flush),
    .fe_gate   (fe_gate)
);

// File: tb/loop_replay_buf_tb_top.sv
module loop_replay_buf_tb_top;

    localparam int CLK_P = 10;
    localparam int DEPTH = 48;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_uop = '0;
    logic        in_loop_start = 1'b0;
    logic        in_loop_end = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_uop;
    logic        loop_exit = 1'b0;
    logic        flush = 1'b0;
    logic        fe_gate;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    // behavioural model: 0 pass, 1 recording, 2 playback
    int          m_state = 0;
    logic [31:0] m_q[$];
    int          m_rd = 0;

    always #(CLK_P/2) clk = ~clk;

    loop_replay_buf dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_uop(in_uop), .in_loop_start(in_loop_start), .in_loop_end(in_loop_end),
        .out_valid(out_valid), .out_ready(out_ready), .out_uop(out_uop),
        .loop_exit(loop_exit), .flush(flush), .fe_gate(fe_gate)
    );

    task automatic chk(string t, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", t, what, act, exp, $time);
        end
    endtask

    task automatic step(logic r, logic iv, logic [31:0] iu, logic st, logic en,
                        logic ordy, logic fl, logic ex);
        logic e_ov, e_ir, e_gate;
        logic [31:0] e_ou;
        @(negedge clk);
        rst = r; in_valid = iv; in_uop = iu; in_loop_start = st;
        in_loop_end = en; out_ready = ordy; flush = fl; loop_exit = ex;
        #1;
        if (fl && !r) begin
            e_ov = 0; e_ir = 0; e_gate = 0; e_ou = '0;
        end else if (m_state == 2 && !r) begin
            e_ov = !ex; e_ir = 0; e_gate = !ex; e_ou = m_q[m_rd];
        end else begin
            e_ov = iv; e_ir = ordy; e_gate = 0; e_ou = iu;
        end
        chk(fl ? "R10" : tag, "out_valid", 32'(out_valid), 32'(e_ov));
        chk(fl ? "R10" : tag, "in_ready", 32'(in_ready), 32'(e_ir));
        chk("R8", "fe_gate", 32'(fe_gate), 32'(e_gate));
        if (e_ov) chk(tag, "out_uop", out_uop, e_ou);
        @(posedge clk);
        if (r || fl) begin
            m_state = 0; m_q.delete(); m_rd = 0;
        end else begin
            case (m_state)
                0: if (iv && ordy && st) begin
                    m_q.delete(); m_q.push_back(iu); m_rd = 0;
                    m_state = en ? 2 : 1;
                end
                1: if (iv && ordy) begin
                    m_q.push_back(iu);
                    if (en) begin
                        m_state = 2; m_rd = 0;
                    end else if (m_q.size() == DEPTH) begin
                        m_state = 0; m_q.delete();
                    end
                end
                default: if (ex) begin
                    m_state = 0; m_q.delete();
                end else if (ordy) begin
                    m_rd = (m_rd == m_q.size() - 1) ? 0 : m_rd + 1;
                end
            endcase
        end
    endtask

    // plain pass/record cycle
    task automatic feed(logic [31:0] u, logic st, logic en);
        step(0, 1, u, st, en, 1, 0, 0);
    endtask

    // replay cycle; input side pushes junk that must be ignored
    task automatic play(logic ordy);
        step(0, 1, 32'hDEAD_0000 | 32'($time), 0, 0, ordy, 0, 0);
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state and first cycle after it
        tag = "R1";
        for (int i = 0; i < 3; i++) step(1, i[0], 32'h100 + 32'(i), 0, 0, 1, 0, 0);
        step(0, 1, 32'h111, 0, 0, 1, 0, 0);

        // R2: pass-through with backpressure and an end hint that is ignored (R4)
        tag = "R2";
        for (int i = 0; i < 8; i++) step(0, i[1], 32'h200 + 32'(i), 0, 0, i[0], 0, 0);
        tag = "R4";
        feed(32'h2FF, 0, 1);
        play(1);

        // R3/R5: five-micro-op body, stalled start attempt first (not accepted)
        tag = "R3";
        step(0, 1, 32'h300, 1, 0, 0, 0, 0);
        feed(32'h301, 1, 0);
        feed(32'h302, 1, 0);   // start hint while recording: ignored
        feed(32'h303, 0, 0);
        step(0, 1, 32'h3AA, 0, 0, 0, 0, 0); // stalled, not recorded
        feed(32'h304, 0, 0);
        tag = "R4";
        feed(32'h305, 0, 1);
        tag = "R5";
        for (int i = 0; i < 13; i++) play(1);
        tag = "R9";
        step(0, 1, 32'h3EE, 0, 0, 1, 0, 1);
        step(0, 1, 32'h3EF, 0, 0, 1, 0, 0);

        // R6: three-micro-op body replayed with stalls, then flushed (R10)
        tag = "R6";
        feed(32'h600, 1, 0);
        feed(32'h601, 0, 0);
        feed(32'h602, 0, 1);
        for (int i = 0; i < 12; i++) play(i % 3 != 0);
        tag = "R10";
        step(0, 1, 32'h6F0, 0, 0, 1, 1, 0);
        step(0, 1, 32'h6F1, 0, 0, 1, 0, 0);

        // R4: one-micro-op body
        tag = "R4";
        feed(32'h400, 1, 1);
        for (int i = 0; i < 4; i++) play(1);
        tag = "R9";
        step(0, 0, 32'h0, 0, 0, 0, 0, 1);

        // R7: overflow drops the recording
        tag = "R7";
        feed(32'h700, 1, 0);
        for (int i = 1; i < DEPTH; i++) feed(32'h700 + 32'(i), 0, 0);
        feed(32'h7F0, 0, 1);   // end hint now in pass-through: ignored
        play(1);
        // R7: exactly DEPTH micro-ops is kept
        feed(32'h800, 1, 0);
        for (int i = 1; i < DEPTH - 1; i++) feed(32'h800 + 32'(i), 0, 0);
        feed(32'h800 + 32'(DEPTH - 1), 0, 1);
        for (int i = 0; i < 2 * DEPTH + 5; i++) play(1);
        tag = "R9";
        step(0, 1, 32'h8EE, 0, 0, 1, 0, 1);

        // R10: flush while recording discards the body
        tag = "R10";
        feed(32'hA00, 1, 0);
        feed(32'hA01, 0, 0);
        step(0, 1, 32'hA02, 0, 1, 1, 1, 0);
        feed(32'hA03, 0, 1);
        feed(32'hA04, 0, 0);
        step(0, 0, 32'h0, 0, 0, 1, 0, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule